// File: doc/BRIEF.md
# Multicore Debug Halt Propagator

This block ties the debug halts of a cluster of cores together. Each core presents a four-bit vector of halt causes. When a core that belongs to a programmable select set is halted for a cause that software has enabled, the block raises a halt request to every other core in the select set. The cause enables and the select set are written by a single command. A second core mask decides which halted cores stop a shared free-running cluster counter. The block drives only the freeze enable of that counter; it does not hold the counter itself.

Software configures the block through a command port. Each command carries an opcode, a four-bit parameter and a core-wide data word. A readback register returns the select set, the cause enables, the counter mask or the feature version. Software can read the feature version to learn whether the counter-mask commands are present.

Top module: `mc_halt_propagator`

## Requirements
- R1: While `rst` is high at a clock edge, the select set, the cause enables, the counter mask, `rdback`, `halt_req` and `ctr_freeze` all become zero, so nothing propagates after reset.
- R2: A command with `cmd_valid` high and opcode 0x1 loads the cause enables from `cmd_param` and the select set from `cmd_data` (bit i is core i). The cause bit order, in both the enables and each core's field `core_cause[4i+3:4i]`, is: bit 0 status halt flag, bit 1 actionpoint hit, bit 2 breakpoint, bit 3 self-halt.
- R3: A core counts as an originator only when it is in the select set and at least one of its cause bits is also set in the cause enables. A cause that is not enabled does not start propagation.
- R4: `halt_req[i]` is high in the cycle after core i is in the select set and some other core is an originator. A lone originator does not request a halt of itself.
- R5: A core outside the select set never receives a halt request and never originates one.
- R6: Halt requests stay asserted while an originator remains, and they fall in the cycle after no core other than the receiver is an originator.
- R7: Opcode 0x4 loads the counter mask from `cmd_data`. `ctr_freeze` is high in the cycle after any core in the counter mask has any cause bit set, whatever the cause enables and the select set hold.
- R8: Opcodes 0x2, 0x3 and 0x5 load `rdback`, zero-extended and visible after the command's clock edge, with the select set, the cause enables and the counter mask respectively.
- R9: Opcode 0x6 loads `rdback` with parameter `FEAT_VER`. When `FEAT_VER` is below 3, opcodes 0x4 and 0x5 are treated as unknown.
- R10: An unknown opcode (0x0, 0x7 to 0xF), or any command presented while `cmd_valid` is low, leaves every mask and `rdback` unchanged. Write commands also leave `rdback` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, one command per cycle |
| cmd_op | input | 4 | Command opcode |
| cmd_param | input | 4 | Command parameter (cause enables for opcode 0x1) |
| cmd_data | input | NUM_CORES | Command data (core mask) |
| core_cause | input | 4*NUM_CORES | Per-core halt-cause vectors, core i at bits 4i+3:4i |
| rdback | output | RB_W | Readback register |
| halt_req | output | NUM_CORES | Per-core halt requests |
| ctr_freeze | output | 1 | Freeze enable for the shared cluster counter |

## Verification
Random cause vectors are mixed with random commands, so propagation is tried while the select set, the enables and the counter mask change underneath it. Directed cases separate a single originator, which must not halt itself, from two simultaneous originators, which must each halt the other. A cause that is set but not enabled tells cause filtering apart from plain halt detection. A core that is halted in the counter mask but not in the select set tells the freeze path apart from the propagation path. Unknown opcodes and idle strobes are followed by readbacks, so that any disturbance of the state becomes visible at `rdback`.

// File: rtl/dbg_halt_pkg.sv
package dbg_halt_pkg;

    localparam int CAUSE_W = 4;
    localparam int CTR_MIN_VER = 3;

    typedef enum logic [3:0] {
        OP_SET_HALT  = 4'h1,
        OP_RD_SEL    = 4'h2,
        OP_RD_CAUSE  = 4'h3,
        OP_SET_CTR   = 4'h4,
        OP_RD_CTR    = 4'h5,
        OP_RD_VER    = 4'h6
    } hp_op_e;

    // bit 0 status flag, bit 1 actionpoint, bit 2 breakpoint, bit 3 self-halt
    typedef struct packed {
        logic self_halt;
        logic brkpt;
        logic actpt;
        logic stat_flag;
    } hp_cause_t;

    function automatic logic op_known(input logic [3:0] op, input int ver);
        case (op)
            OP_SET_HALT, OP_RD_SEL, OP_RD_CAUSE, OP_RD_VER: return 1'b1;
            OP_SET_CTR, OP_RD_CTR: return (ver >= CTR_MIN_VER);
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/hp_cmd_regs.sv
module hp_cmd_regs
    import dbg_halt_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int RB_W      = 32,
    parameter int FEAT_VER  = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cmd_valid,
    input  logic [3:0]           cmd_op,
    input  logic [CAUSE_W-1:0]   cmd_param,
    input  logic [NUM_CORES-1:0] cmd_data,
    output logic [NUM_CORES-1:0] sel_mask,
    output hp_cause_t            cause_en,
    output logic [NUM_CORES-1:0] ctr_mask,
    output logic [RB_W-1:0]      rdback
);

    localparam bit HAS_CTR = (FEAT_VER >= CTR_MIN_VER);

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_mask <= '0;
            cause_en <= '0;
            ctr_mask <= '0;
            rdback   <= '0;
        end else if (cmd_valid) begin
            case (cmd_op)
                OP_SET_HALT: begin
                    cause_en <= hp_cause_t'(cmd_param);
                    sel_mask <= cmd_data;
                end
                OP_RD_SEL:   rdback <= RB_W'(sel_mask);
                OP_RD_CAUSE: rdback <= RB_W'(cause_en);
                OP_SET_CTR:  if (HAS_CTR) ctr_mask <= cmd_data;
                OP_RD_CTR:   if (HAS_CTR) rdback <= RB_W'(ctr_mask);
                OP_RD_VER:   rdback <= RB_W'(FEAT_VER);
                default: ;
            endcase
        end
    end

    AST_UNKNOWN_OP_KEEPS_RDBACK: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !op_known(cmd_op, FEAT_VER)) |=> $stable(rdback)); // R10

    AST_UNKNOWN_OP_KEEPS_MASKS: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !op_known(cmd_op, FEAT_VER)) |=>
        ($stable(sel_mask) && $stable(cause_en) && $stable(ctr_mask))); // R10

    AST_IDLE_KEEPS_STATE: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid |=> ($stable(rdback) && $stable(sel_mask) && $stable(ctr_mask))); // R10

    AST_RESET_CLEARS_MASKS: assert property (@(posedge clk)
        $past(rst) |-> (sel_mask == '0 && cause_en == '0 && ctr_mask == '0 && rdback == '0)); // R1

endmodule

// File: rtl/hp_cause_filter.sv
module hp_cause_filter
    import dbg_halt_pkg::*;
#(
    parameter int NUM_CORES = 4
) (
    input  logic [NUM_CORES*CAUSE_W-1:0] core_cause,
    input  logic [NUM_CORES-1:0]         sel_mask,
    input  hp_cause_t                    cause_en,
    output logic [NUM_CORES-1:0]         origin,
    output logic [NUM_CORES-1:0]         halted
);

    for (genvar i = 0; i < NUM_CORES; i++) begin : g_core
        hp_cause_t cur;
        assign cur       = hp_cause_t'(core_cause[i*CAUSE_W +: CAUSE_W]);
        assign halted[i] = |cur;
        assign origin[i] = sel_mask[i] & (|(cur & cause_en));
    end

endmodule

// File: rtl/hp_req_gen.sv
module hp_req_gen
    import dbg_halt_pkg::*;
#(
    parameter int NUM_CORES = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_CORES-1:0] origin,
    input  logic [NUM_CORES-1:0] halted,
    input  logic [NUM_CORES-1:0] sel_mask,
    input  logic [NUM_CORES-1:0] ctr_mask,
    output logic [NUM_CORES-1:0] halt_req,
    output logic                 ctr_freeze
);

    logic [NUM_CORES-1:0] req_nxt;

    for (genvar i = 0; i < NUM_CORES; i++) begin : g_req
        localparam logic [NUM_CORES-1:0] SELF = NUM_CORES'(1) << i;
        assign req_nxt[i] = sel_mask[i] & (|(origin & ~SELF));

        AST_LONE_ORIGIN_NOT_SELF: assert property (@(posedge clk) disable iff (rst)
            (origin == SELF) |=> !halt_req[i]); // R4

        AST_UNSELECTED_NO_REQ: assert property (@(posedge clk) disable iff (rst)
            !sel_mask[i] |=> !halt_req[i]); // R5
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            halt_req   <= '0;
            ctr_freeze <= 1'b0;
        end else begin
            halt_req   <= req_nxt;
            ctr_freeze <= |(ctr_mask & halted);
        end
    end

    AST_NO_ORIGIN_NO_REQ: assert property (@(posedge clk) disable iff (rst)
        (origin == '0) |=> (halt_req == '0)); // R6

    AST_FREEZE_FOLLOWS_HALT: assert property (@(posedge clk) disable iff (rst)
        ((ctr_mask & halted) != '0) |=> ctr_freeze); // R7

endmodule

// File: rtl/mc_halt_propagator.sv
module mc_halt_propagator
    import dbg_halt_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int RB_W      = 32,
    parameter int FEAT_VER  = 3
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         cmd_valid,
    input  logic [3:0]                   cmd_op,
    input  logic [3:0]                   cmd_param,
    input  logic [NUM_CORES-1:0]         cmd_data,
    input  logic [NUM_CORES*4-1:0]       core_cause,
    output logic [RB_W-1:0]              rdback,
    output logic [NUM_CORES-1:0]         halt_req,
    output logic                         ctr_freeze
);

    logic [NUM_CORES-1:0] sel_mask;
    logic [NUM_CORES-1:0] ctr_mask;
    hp_cause_t            cause_en;
    logic [NUM_CORES-1:0] origin;
    logic [NUM_CORES-1:0] halted;

    hp_cmd_regs #(
        .NUM_CORES (NUM_CORES),
        .RB_W      (RB_W),
        .FEAT_VER  (FEAT_VER)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_param (cmd_param),
        .cmd_data  (cmd_data),
        .sel_mask  (sel_mask),
        .cause_en  (cause_en),
        .ctr_mask  (ctr_mask),
        .rdback    (rdback)
    );

    hp_cause_filter #(
        .NUM_CORES (NUM_CORES)
    ) u_filter (
        .core_cause (core_cause),
        .sel_mask   (sel_mask),
        .cause_en   (cause_en),
        .origin     (origin),
        .halted     (halted)
    );

    hp_req_gen #(
        .NUM_CORES (NUM_CORES)
    ) u_req (
        .clk        (clk),
        .rst        (rst),
        .origin     (origin),
        .halted     (halted),
        .sel_mask   (sel_mask),
        .ctr_mask   (ctr_mask),
        .halt_req   (halt_req),
        .ctr_freeze (ctr_freeze)
    );

    AST_RESET_OUTPUTS_LOW: assert property (@(posedge clk)
        $past(rst) |-> (halt_req == '0 && !ctr_freeze)); // R1

endmodule

// File: tb/mc_halt_propagator_bench.sv
module mc_halt_propagator_bench;

    localparam int N   = 4;
    localparam int RBW = 32;
    localparam int VER = 3;

    logic           clk = 1'b0;
    logic           rst;
    logic           cmd_valid;
    logic [3:0]     cmd_op;
    logic [3:0]     cmd_param;
    logic [N-1:0]   cmd_data;
    logic [N*4-1:0] core_cause;
    logic [RBW-1:0] rdback;
    logic [N-1:0]   halt_req;
    logic           ctr_freeze;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [N-1:0]   m_sel, m_ctr, e_req;
    logic [3:0]     m_en;
    logic [RBW-1:0] e_rb;
    logic           e_frz;

    always #5 clk = ~clk;

    mc_halt_propagator #(.NUM_CORES(N), .RB_W(RBW), .FEAT_VER(VER)) u_mc_halt_propagator (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_param(cmd_param), .cmd_data(cmd_data), .core_cause(core_cause),
        .rdback(rdback), .halt_req(halt_req), .ctr_freeze(ctr_freeze)
    );

    function automatic logic [N-1:0] f_origin(logic [N-1:0] sel, logic [3:0] en, logic [N*4-1:0] cc);
        logic [N-1:0] o;
        for (int i = 0; i < N; i++) o[i] = sel[i] && ((cc[i*4 +: 4] & en) != 4'h0);
        return o;
    endfunction

    function automatic logic [N-1:0] f_req(logic [N-1:0] sel, logic [3:0] en, logic [N*4-1:0] cc);
        logic [N-1:0] o, r;
        o = f_origin(sel, en, cc);
        for (int i = 0; i < N; i++) begin
            logic [N-1:0] others;
            others = o;
            others[i] = 1'b0;
            r[i] = sel[i] && (others != '0);
        end
        return r;
    endfunction

    function automatic logic f_frz(logic [N-1:0] cm, logic [N*4-1:0] cc);
        logic f = 1'b0;
        for (int i = 0; i < N; i++) if (cm[i] && cc[i*4 +: 4] != 4'h0) f = 1'b1;
        return f;
    endfunction

    task automatic check(input string tag, input string what, input logic [RBW-1:0] act, input logic [RBW-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // inputs already driven; models one clock edge and compares after it
    task automatic step(input string tag);
        if (rst) begin
            m_sel = '0; m_en = '0; m_ctr = '0; e_rb = '0; e_req = '0; e_frz = 1'b0;
        end else begin
            e_req = f_req(m_sel, m_en, core_cause);
            e_frz = f_frz(m_ctr, core_cause);
            if (cmd_valid) begin
                case (cmd_op)
                    4'h1: begin m_en = cmd_param; m_sel = cmd_data; end
                    4'h2: e_rb = RBW'(m_sel);
                    4'h3: e_rb = RBW'(m_en);
                    4'h4: m_ctr = cmd_data;
                    4'h5: e_rb = RBW'(m_ctr);
                    4'h6: e_rb = RBW'(VER);
                    default: ;
                endcase
            end
        end
        @(posedge clk);
        @(negedge clk);
        check(tag, "halt_req", RBW'(halt_req), RBW'(e_req));
        check(tag, "ctr_freeze", RBW'(ctr_freeze), RBW'(e_frz));
        check(tag, "rdback", rdback, e_rb);
    endtask

    task automatic cmd(input logic [3:0] op, input logic [3:0] prm, input logic [N-1:0] d, input string tag);
        cmd_valid = 1'b1; cmd_op = op; cmd_param = prm; cmd_data = d;
        step(tag);
        cmd_valid = 1'b0;
    endtask

    task automatic idle(input string tag);
        cmd_valid = 1'b0;
        step(tag);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(32'h5EED_1234));
        rst = 1'b1; cmd_valid = 1'b0; cmd_op = '0; cmd_param = '0; cmd_data = '0;
        core_cause = {N{4'hF}};
        @(negedge clk);
        step("R1"); step("R1");
        rst = 1'b0;
        idle("R1");                          // masks zero: causes do nothing
        cmd(4'h2, 4'h0, '0, "R1");           // select set reads zero
        cmd(4'h5, 4'h0, '0, "R1");           // counter mask reads zero

        // R2 / R8: program and read back
        core_cause = '0;
        cmd(4'h1, 4'h5, 4'b0111, "R2");
        cmd(4'h2, 4'h0, '0, "R8");
        cmd(4'h3, 4'h0, '0, "R8");
        cmd(4'h6, 4'h0, '0, "R9");

        // R3: breakpoint (bit 2) enabled, actionpoint (bit 1) not enabled
        core_cause = '0; core_cause[1*4 +: 4] = 4'b0010;
        idle("R3"); idle("R3");
        // R4: lone originator core 1 via breakpoint
        core_cause[1*4 +: 4] = 4'b0100;
        idle("R4"); idle("R4");
        // R4: two originators halt each other
        core_cause[0*4 +: 4] = 4'b0001;
        idle("R4");
        // R5: core 3 unselected, halted with every cause
        core_cause = '0; core_cause[3*4 +: 4] = 4'hF;
        idle("R5");
        core_cause[0*4 +: 4] = 4'b0001;
        idle("R5");
        // R6: drop all causes, requests fall
        core_cause = '0;
        idle("R6"); idle("R6");

        // R7: counter mask on unselected core 3
        cmd(4'h4, 4'h0, 4'b1000, "R7");
        cmd(4'h5, 4'h0, '0, "R8");
        core_cause[3*4 +: 4] = 4'b1000;
        idle("R7"); idle("R7");
        core_cause = '0;
        idle("R7");

        // R10: unknown opcodes and idle strobes leave state alone
        cmd(4'h0, 4'hF, 4'b1111, "R10");
        cmd(4'h7, 4'hF, 4'b1111, "R10");
        cmd(4'hF, 4'hF, 4'b1111, "R10");
        cmd_op = 4'h1; cmd_param = 4'h0; cmd_data = '0; cmd_valid = 1'b0;
        step("R10");
        cmd(4'h2, 4'h0, '0, "R10");
        cmd(4'h1, 4'h3, 4'b0101, "R10");     // write keeps readback
        cmd(4'h3, 4'h0, '0, "R10");

        // random mix
        for (int k = 0; k < 3000; k++) begin
            core_cause = N*4'($urandom);
            if ($urandom_range(0, 3) == 0) begin
                cmd_valid = 1'b1;
                cmd_op    = 4'($urandom_range(0, 9));
                cmd_param = 4'($urandom);
                cmd_data  = N'($urandom);
            end else begin
                cmd_valid = 1'b0;
            end
            step("RND");
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule